// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the access address for a four-beat burst on a synchronous memory. On a load cycle it takes a full start address. The two lowest bits of that address become the burst start offset. The upper bits are kept unchanged for the whole burst. Each later advance cycle moves the beat count on by one. The low two address bits then follow either a linear order or an XOR-interleaved order, and a static strap input picks the order.

Every state change depends on an active-low clock enable. While that enable is deasserted, the sequencer keeps its whole state, so a stall stretches the current beat for as many cycles as needed. After reset no address is held, and an advance request has no effect until a load has taken place. The address output is combinational from the internal registers, so it shows the new value in the same cycle that follows the capturing edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low and after its release, with no qualified edge yet, addr_o is 0, beat_o is 0, valid_o is 0 and last_o is 0.
- R2: A rising edge with cen_ni=0 and adv_ld_i=0 loads a new address. After that edge addr_o equals addr_i from that edge, beat_o is 0 and valid_o is 1. This applies whether or not a burst is already in progress.
- R3: A rising edge with cen_ni=0, adv_ld_i=1 and valid_o=1 raises beat_o by one, modulo 4. The beat after 3 is 0.
- R4: With mode_i=0 (linear order), addr_o[1:0] equals (start offset + beat_o) mod 4. For example, a start offset of 1 gives 1,2,3,0.
- R5: With mode_i=1 (interleaved order), addr_o[1:0] equals start offset XOR beat_o. For example, a start offset of 1 gives 1,0,3,2.
- R6: addr_o[ADDR_W-1:2] keeps the value loaded in R2 through every advance, including the wrap from beat 3 to beat 0.
- R7: A rising edge with cen_ni=1 changes nothing. addr_o, beat_o, valid_o and last_o keep their values whatever adv_ld_i and addr_i are.
- R8: An advance (cen_ni=0, adv_ld_i=1) while valid_o=0 has no effect. valid_o stays 0 and beat_o stays 0.
- R9: last_o is 1 exactly when valid_o=1 and beat_o=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low; when high the edge is ignored |
| adv_ld_i | input | 1 | 1 = advance the beat, 0 = load a new address |
| addr_i | input | ADDR_W | Start address, sampled on load |
| mode_i | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current access address |
| beat_o | output | 2 | Beat index within the burst |
| valid_o | output | 1 | A start address has been loaded |
| last_o | output | 1 | Final beat of the four-beat burst |

## Verification
The checker treats mode_i as a strap. The order-step properties therefore hold only when mode_i has the same value in the cycle before an advance and the cycle after it. The properties also assume that cen_ni, adv_ld_i and addr_i are settled at each rising edge. The bench meets both assumptions: it drives every input at the falling edge, and it changes mode_i only together with a load.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned OFS_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef logic [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/bas_capture.sv
module bas_capture #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      base_o  <= addr_i;
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output ofs_t beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_o <= '0;
    else if (clr_i)  beat_o <= '0;
    else if (step_i) beat_o <= beat_o + ofs_t'(1);
  end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import burst_seq_pkg::*;
(
  input  ofs_t   start_i,
  input  ofs_t   beat_i,
  input  order_e order_i,
  output ofs_t   ofs_o
);
  ofs_t lin_ofs;
  ofs_t ilv_ofs;

  assign lin_ofs = start_i + beat_i;

  // bitwise interleave: each offset bit flips with the matching beat bit
  for (genvar b = 0; b < OFS_W; b++) begin : g_ilv
    assign ilv_ofs[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: ofs_o = ilv_ofs;
      default:        ofs_o = lin_ofs;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              adv_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o,
  output logic              valid_o,
  output logic              last_o
);
  localparam int unsigned HI_W = ADDR_W - OFS_W;

  logic              qual;
  logic              load;
  logic              step;
  logic [ADDR_W-1:0] base;
  ofs_t              beat;
  ofs_t              ofs;
  order_e            order;

  assign qual  = ~cen_ni;
  assign load  = qual & ~adv_ld_i;
  assign step  = qual & adv_ld_i & valid_o;
  assign order = order_e'(mode_i);

  bas_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .base_o (base),
    .valid_o(valid_o)
  );

  bas_beat_ctr u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .step_i (step),
    .beat_o (beat)
  );

  bas_order_map u_map (
    .start_i(base[OFS_W-1:0]),
    .beat_i (beat),
    .order_i(order),
    .ofs_o  (ofs)
  );

  assign addr_o = {base[ADDR_W-1 -: HI_W], ofs};
  assign beat_o = beat;
  assign last_o = valid_o & (&beat);
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cen_ni,
  input logic              adv_ld_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        beat_o,
  input logic              valid_o,
  input logic              last_o
);
  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !adv_ld_i) |=> (addr_o == $past(addr_i) && beat_o == 2'd0 && valid_o)); // R2

  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && adv_ld_i && valid_o) |=> (beat_o == $past(beat_o) + 2'd1)); // R3

  AST_LIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && adv_ld_i && valid_o && !mode_i) |=>
      (mode_i || addr_o[1:0] == $past(addr_o[1:0]) + 2'd1)); // R4

  AST_ILV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && adv_ld_i && valid_o && mode_i) |=>
      (!mode_i || (addr_o[1:0] ^ beat_o) == $past(addr_o[1:0] ^ beat_o))); // R5

  AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && adv_ld_i) |=> $stable(addr_o[ADDR_W-1:2])); // R6

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> ($stable(beat_o) && $stable(valid_o) && $stable(addr_o[ADDR_W-1:2]))); // R7

  AST_NO_ADV_UNLOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && adv_ld_i && !valid_o) |=> (!valid_o && beat_o == 2'd0)); // R8

  AST_LAST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !cen_ni && adv_ld_i) |=> (!last_o && beat_o == 2'd0)); // R9
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W)) u_bas_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cen_ni  (cen_ni),
  .adv_ld_i(adv_ld_i),
  .addr_i  (addr_i),
  .mode_i  (mode_i),
  .addr_o  (addr_o),
  .beat_o  (beat_o),
  .valid_o (valid_o),
  .last_o  (last_o)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int unsigned ADDR_W = 18;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cen_ni = 1'b1;
  logic              adv_ld_i = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              mode_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;
  logic [1:0]        beat_o;
  logic              valid_o;
  logic              last_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cen_ni(cen_ni), .adv_ld_i(adv_ld_i),
    .addr_i(addr_i), .mode_i(mode_i), .addr_o(addr_o), .beat_o(beat_o),
    .valid_o(valid_o), .last_o(last_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns after the next rising edge
  task automatic cyc(input logic cen, input logic adv, input logic [ADDR_W-1:0] a);
    @(negedge clk_i);
    cen_ni = cen; adv_ld_i = adv; addr_i = a;
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [1:0] exp_ofs(input logic m, input logic [1:0] s, input logic [1:0] b);
    return m ? (s ^ b) : (s + b);
  endfunction

  task automatic t_reset();
    chk("R1 addr", 32'(addr_o), 0);
    chk("R1 beat", 32'(beat_o), 0);
    chk("R1 valid", 32'(valid_o), 0);
    chk("R1 last", 32'(last_o), 0);
  endtask

  task automatic t_adv_unloaded();
    cyc(1'b0, 1'b1, 18'h3ffff);
    chk("R8 valid", 32'(valid_o), 0);
    chk("R8 beat", 32'(beat_o), 0);
    chk("R8 addr", 32'(addr_o), 0);
  endtask

  task automatic t_burst(input logic m, input logic [1:0] s, input logic [ADDR_W-3:0] up);
    logic [ADDR_W-1:0] a = {up, s};
    logic [1:0] b = 2'd0;
    @(negedge clk_i); mode_i = m;
    cyc(1'b0, 1'b0, a);
    chk("R2 addr", 32'(addr_o), 32'(a));
    chk("R2 beat", 32'(beat_o), 0);
    chk("R2 valid", 32'(valid_o), 1);
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 1'b1, ~a);
      b = b + 2'd1;
      chk("R3 beat", 32'(beat_o), 32'(b));
      chk(m ? "R5 ilv ofs" : "R4 lin ofs", 32'(addr_o[1:0]), 32'(exp_ofs(m, s, b)));
      chk("R6 upper", 32'(addr_o[ADDR_W-1:2]), 32'(up));
      chk("R9 last", 32'(last_o), 32'(b == 2'd3));
    end
  endtask

  task automatic t_stall(input logic m);
    logic [ADDR_W-1:0] a = 18'h2a5a6;
    @(negedge clk_i); mode_i = m;
    cyc(1'b0, 1'b0, a);
    cyc(1'b0, 1'b1, '0);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, i[0], 18'h01234);
      chk("R7 beat", 32'(beat_o), 1);
      chk("R7 addr", 32'(addr_o), 32'({a[ADDR_W-1:2], exp_ofs(m, a[1:0], 2'd1)}));
      chk("R7 valid", 32'(valid_o), 1);
    end
    cyc(1'b0, 1'b1, '0);
    chk("R7 resume beat", 32'(beat_o), 2);
    chk("R7 resume addr", 32'(addr_o[1:0]), 32'(exp_ofs(m, a[1:0], 2'd2)));
    cyc(1'b0, 1'b1, '0);
    cyc(1'b1, 1'b1, '0);
    chk("R9 last held in stall", 32'(last_o), 1);
  endtask

  task automatic t_reload_mid();
    @(negedge clk_i); mode_i = 1'b0;
    cyc(1'b0, 1'b0, 18'h10001);
    cyc(1'b0, 1'b1, '0);
    cyc(1'b0, 1'b0, 18'h0fffe);
    chk("R2 reload addr", 32'(addr_o), 32'h0fffe);
    chk("R2 reload beat", 32'(beat_o), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    t_reset();
    t_adv_unloaded();
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        t_burst(m[0], s[1:0], 16'(16'h5a3c + s + 16 * m));
    t_stall(1'b0);
    t_stall(1'b1);
    t_reload_mid();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule